// File: doc/BRIEF.md
# Clock and Power Mode Controller

This block moves a chip between five power modes and drives the controls that each mode needs. Full-on runs the PLL unbypassed with both clocks on. Active keeps the PLL running but bypasses it, so both clocks run at the input clock rate. Sleep stops only the core clock. Deep sleep turns off the PLL and both clocks. Hibernate does the same and also removes core power.

The block also owns the PLL clock multiplier. A new ratio written in full-on takes effect at once. A ratio written in any other mode is held and takes effect when full-on is next entered.

A mode request is accepted only from full-on or active. Sleep, deep sleep and hibernate are left only by a wake event. Sleep returns to the mode it was entered from. Deep sleep and hibernate restart the PLL in bypass, wait for a lock input, and then enter full-on. During that wait a busy flag is raised and mode requests are ignored.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode is full-on (code 0). pllEnable=1, pllBypass=0, coreClkEn=1, sysClkEn=1, corePowerEn=1, busy=0 and multiplier equals the parameter MULT_INIT.
- R2: Mode codes are: full-on 0, active 1, sleep 2, deep sleep 3, hibernate 4. The outputs {pllEnable, pllBypass, coreClkEn, sysClkEn, corePowerEn} for each mode are:
  - full-on: 1,0,1,1,1
  - active: 1,1,1,1,1
  - sleep: 1,b,0,1,1, where b=1 if sleep was entered from active and b=0 otherwise
  - deep sleep: 0,1,0,0,1
  - hibernate: 0,1,0,0,0
- R3: In full-on or active, a request with reqValid=1 and reqMode in 0..4 that differs from the current mode sets curMode to reqMode at the next clock edge. Codes 5..7 are ignored.
- R4: In sleep, requests are ignored. A wake event returns curMode to the mode sleep was entered from at the next edge.
- R5: A wake in deep sleep or hibernate starts a lock wait. During the wait curMode keeps its old value, busy=1, and the outputs are 1,1,0,0,1. At the edge where pllLock=1 is sampled, curMode becomes full-on and busy becomes 0.
- R6: Mode requests made while busy=1 have no effect. A wake event has no effect in full-on or active.
- R7: A multiplier write (multWrite=1) while in full-on and not busy loads multNew into multiplier at the next edge.
- R8: A multiplier write in any other state leaves multiplier unchanged and is held pending. A later write replaces the pending value. The pending value is loaded at the edge that enters full-on. If nothing is pending, multiplier is unchanged at that edge.
- R9: A multiplier write made in the same cycle as a transition into full-on wins over any pending value, and is applied at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Mode request strobe |
| reqMode | input | 3 | Requested mode code |
| wake | input | 1 | Wake event |
| multWrite | input | 1 | Multiplier write strobe |
| multNew | input | MULT_W | New multiplier value |
| pllLock | input | 1 | PLL lock indication |
| pllEnable | output | 1 | PLL enable |
| pllBypass | output | 1 | PLL bypass select |
| coreClkEn | output | 1 | Core clock enable |
| sysClkEn | output | 1 | System clock enable |
| corePowerEn | output | 1 | Core power enable |
| curMode | output | 3 | Current mode code |
| busy | output | 1 | Lock wait in progress |
| multiplier | output | MULT_W | Applied multiplier |

## Verification
Two functions can meet on the same edge: a multiplier write and a transition into full-on. The bench provokes this in three ways:
- a write issued with the request that takes active back to full-on;
- a write issued with a sleep wake that returns to full-on;
- a write issued on the cycle that pllLock ends a lock wait while an older value is pending.

A behavioural model in the bench tracks the mode, the pending value and the applied value. It is compared with every output at each clock. This shows whether the fresh write or the stale pending value lands.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_FULL   = 3'd0,
    MODE_ACTIVE = 3'd1,
    MODE_SLEEP  = 3'd2,
    MODE_DEEP   = 3'd3,
    MODE_HIBER  = 3'd4
  } pwrMode_e;

  typedef struct packed {
    pwrMode_e mode;
    logic     lockWait;
    logic     bypassHeld;
    logic     loadDirect;
    logic     enterFull;
  } ctrlStrobe_t;
endpackage

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [MODE_W-1:0] reqMode,
  input  logic              wake,
  input  logic              multWrite,
  input  logic              pllLock,
  output ctrlStrobe_t       strobe
);
  localparam logic [MODE_W-1:0] LAST_CODE = MODE_W'(MODE_HIBER);

  pwrMode_e mode, modeNext, savedMode, savedNext;
  logic     lockWait, lockWaitNext, enterNext;
  logic     reqOk;

  assign reqOk = reqValid && (reqMode <= LAST_CODE) && (reqMode != mode);

  always_comb begin
    modeNext     = mode;
    savedNext    = savedMode;
    lockWaitNext = lockWait;
    enterNext    = 1'b0;
    if (lockWait) begin
      if (pllLock) begin
        lockWaitNext = 1'b0;
        modeNext     = MODE_FULL;
        enterNext    = 1'b1;
      end
    end else begin
      case (mode)
        MODE_FULL, MODE_ACTIVE: begin
          if (reqOk) begin
            modeNext  = pwrMode_e'(reqMode);
            enterNext = (pwrMode_e'(reqMode) == MODE_FULL);
            if (pwrMode_e'(reqMode) == MODE_SLEEP) savedNext = mode;
          end
        end
        MODE_SLEEP: begin
          if (wake) begin
            modeNext  = savedMode;
            enterNext = (savedMode == MODE_FULL);
          end
        end
        MODE_DEEP, MODE_HIBER: begin
          if (wake) lockWaitNext = 1'b1;
        end
        default: modeNext = MODE_FULL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode      <= MODE_FULL;
      savedMode <= MODE_FULL;
      lockWait  <= 1'b0;
    end else begin
      mode      <= modeNext;
      savedMode <= savedNext;
      lockWait  <= lockWaitNext;
    end
  end

  always_comb begin
    strobe.mode       = mode;
    strobe.lockWait   = lockWait;
    strobe.bypassHeld = (savedMode == MODE_ACTIVE);
    strobe.loadDirect = multWrite && (mode == MODE_FULL) && !lockWait;
    strobe.enterFull  = enterNext;
  end

  // R5: the lock wait ends in full-on one edge after lock is seen
  a_r5_lock_exit: assert property (@(posedge clk) disable iff (!rstN)
    lockWait && pllLock |=> (mode == MODE_FULL) && !lockWait);

  // R6: while busy and unlocked, the mode holds
  a_r6_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    lockWait && !pllLock |=> $stable(mode));

  // R4: a wake from sleep returns to the mode sleep was entered from
  a_r4_sleep_return: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_SLEEP) && wake && !lockWait |=> mode == $past(savedMode));

  // R3: out-of-range codes never move the mode
  a_r3_bad_code: assert property (@(posedge clk) disable iff (!rstN)
    ((mode == MODE_FULL) || (mode == MODE_ACTIVE)) && !lockWait &&
    reqValid && (reqMode > LAST_CODE) |=> $stable(mode));
endmodule

// File: rtl/pmc_datapath.sv
module pmc_datapath
  import pmc_pkg::*;
#(
  parameter int MULT_W    = 6,
  parameter int MULT_INIT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              multWrite,
  input  logic [MULT_W-1:0] multNew,
  output logic              pllEnable,
  output logic              pllBypass,
  output logic              coreClkEn,
  output logic              sysClkEn,
  output logic              corePowerEn,
  output logic [MULT_W-1:0] multiplier
);
  localparam logic [MULT_W-1:0] INIT_VAL = MULT_W'(MULT_INIT);

  logic [MULT_W-1:0] pendVal;
  logic              pendValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      multiplier <= INIT_VAL;
      pendVal    <= '0;
      pendValid  <= 1'b0;
    end else begin
      if (strobe.loadDirect) begin
        multiplier <= multNew;
      end else if (strobe.enterFull) begin
        if (multWrite)      multiplier <= multNew;
        else if (pendValid) multiplier <= pendVal;
      end
      if (strobe.enterFull) begin
        pendValid <= 1'b0;
      end else if (multWrite && !strobe.loadDirect) begin
        pendVal   <= multNew;
        pendValid <= 1'b1;
      end
    end
  end

  logic [4:0] ctl;
  always_comb begin
    if (strobe.lockWait) ctl = 5'b11001;
    else begin
      case (strobe.mode)
        MODE_FULL:   ctl = 5'b10111;
        MODE_ACTIVE: ctl = 5'b11111;
        MODE_SLEEP:  ctl = {1'b1, strobe.bypassHeld, 3'b011};
        MODE_DEEP:   ctl = 5'b01001;
        MODE_HIBER:  ctl = 5'b01000;
        default:     ctl = 5'b10111;
      endcase
    end
  end
  assign {pllEnable, pllBypass, coreClkEn, sysClkEn, corePowerEn} = ctl;

  // R7: a direct write lands on the next edge
  a_r7_direct_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadDirect |=> multiplier == $past(multNew));

  // R8: outside direct writes and full-on entry the ratio holds
  a_r8_ratio_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadDirect && !strobe.enterFull |=> $stable(multiplier));

  // R2: with core power off, PLL and clocks are off
  a_r2_power_off: assert property (@(posedge clk) disable iff (!rstN)
    !corePowerEn |-> !coreClkEn && !sysClkEn && !pllEnable);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int MULT_W    = 6,
  parameter int MULT_INIT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqMode,
  input  logic              wake,
  input  logic              multWrite,
  input  logic [MULT_W-1:0] multNew,
  input  logic              pllLock,
  output logic              pllEnable,
  output logic              pllBypass,
  output logic              coreClkEn,
  output logic              sysClkEn,
  output logic              corePowerEn,
  output logic [2:0]        curMode,
  output logic              busy,
  output logic [MULT_W-1:0] multiplier
);
  ctrlStrobe_t strobe;

  pmc_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
    .wake(wake), .multWrite(multWrite), .pllLock(pllLock), .strobe(strobe)
  );

  pmc_datapath #(.MULT_W(MULT_W), .MULT_INIT(MULT_INIT)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .multWrite(multWrite),
    .multNew(multNew), .pllEnable(pllEnable), .pllBypass(pllBypass),
    .coreClkEn(coreClkEn), .sysClkEn(sysClkEn), .corePowerEn(corePowerEn),
    .multiplier(multiplier)
  );

  assign curMode = strobe.mode;
  assign busy    = strobe.lockWait;
endmodule

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
  localparam int MW = 6;
  localparam int MINIT = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, wake = 1'b0, multWrite = 1'b0, pllLock = 1'b0;
  logic [2:0] reqMode = '0;
  logic [MW-1:0] multNew = '0;
  logic pllEnable, pllBypass, coreClkEn, sysClkEn, corePowerEn, busy;
  logic [2:0] curMode;
  logic [MW-1:0] multiplier;

  int errors = 0, checks = 0, cycles = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  pwr_mode_ctrl #(.MULT_W(MW), .MULT_INIT(MINIT)) i_pwr_mode_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
    .wake(wake), .multWrite(multWrite), .multNew(multNew), .pllLock(pllLock),
    .pllEnable(pllEnable), .pllBypass(pllBypass), .coreClkEn(coreClkEn),
    .sysClkEn(sysClkEn), .corePowerEn(corePowerEn), .curMode(curMode),
    .busy(busy), .multiplier(multiplier)
  );

  // behavioural reference
  int mMode, mSaved, mMult, mPend;
  bit mWait, mPendV;

  always @(posedge clk) begin
    int oldMode;
    bit oldWait, enter;
    oldMode = mMode; oldWait = mWait; enter = 0;
    if (!rstN) begin
      mMode = 0; mSaved = 0; mWait = 0; mMult = MINIT; mPend = 0; mPendV = 0;
    end else begin
      if (mWait) begin
        if (pllLock) begin mWait = 0; mMode = 0; enter = 1; end
      end else if (mMode <= 1) begin
        if (reqValid && reqMode <= 4 && int'(reqMode) != mMode) begin
          if (reqMode == 2) mSaved = mMode;
          mMode = int'(reqMode);
          enter = (reqMode == 0);
        end
      end else if (mMode == 2) begin
        if (wake) begin mMode = mSaved; enter = (mSaved == 0); end
      end else if (wake) mWait = 1;
      if (multWrite && oldMode == 0 && !oldWait) mMult = int'(multNew);
      else if (enter) begin
        if (multWrite) mMult = int'(multNew);
        else if (mPendV) mMult = mPend;
      end
      if (enter) mPendV = 0;
      else if (multWrite && !(oldMode == 0 && !oldWait)) begin
        mPend = int'(multNew); mPendV = 1;
      end
    end
  end

  function automatic logic [4:0] expCtl();
    if (mWait) return 5'b11001;
    case (mMode)
      0: return 5'b10111;
      1: return 5'b11111;
      2: return {1'b1, mSaved == 1, 3'b011};
      3: return 5'b01001;
      default: return 5'b01000;
    endcase
  endfunction

  always @(negedge clk) begin
    logic [5+1+3+MW-1:0] act, exp;
    cycles++;
    act = {pllEnable, pllBypass, coreClkEn, sysClkEn, corePowerEn, busy, curMode, multiplier};
    exp = {expCtl(), mWait, 3'(mMode), MW'(mMult)};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual=%h expected=%h", tag, cycles, act, exp);
    end
    if (cycles > 3000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=<3000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic req(int m);
    reqValid = 1; reqMode = 3'(m); step(); reqValid = 0;
  endtask

  task automatic wr(int v);
    multWrite = 1; multNew = MW'(v); step(); multWrite = 0;
  endtask

  task automatic doWake();
    wake = 1; step(); wake = 0;
  endtask

  initial begin
    step(3); rstN = 1;
    tag = "R1"; step(2);
    tag = "R7"; wr(12); step();
    tag = "R2_R3"; req(1); step();
    tag = "R8"; wr(20); step(); wr(21); step(2);
    tag = "R3"; req(6); step(); req(7); step();
    tag = "R8_entry"; req(0); step();
    tag = "R8_nopend"; req(1); req(0); step();
    tag = "R4"; req(1); req(2); step(); req(0); step(); doWake(); step();
    tag = "R4_full"; req(0); req(2); step(); doWake(); step();
    tag = "R6_wake"; doWake(); req(1); doWake(); step();
    tag = "R5"; req(3); step(); wr(30); doWake(); step();
    req(1); req(0); step(); pllLock = 1; step(); pllLock = 0; step();
    tag = "R5_hib"; req(4); step(); wr(35); doWake(); step(2);
    tag = "R9"; pllLock = 1; multWrite = 1; multNew = 6'd40; step();
    pllLock = 0; multWrite = 0; step();
    tag = "R9_req"; req(1); wr(44);
    reqValid = 1; reqMode = 3'd0; multWrite = 1; multNew = 6'd50; step();
    reqValid = 0; multWrite = 0; step();
    tag = "R9_sleep"; req(2); wr(55); multWrite = 1; multNew = 6'd57; wake = 1; step();
    multWrite = 0; wake = 0; step();
    tag = "R1"; rstN = 0; step(2); rstN = 1; step(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule